// File: doc/BRIEF.md
# Multichannel Quarter-Rate Quadrature Downconverter

This block takes a time-interleaved stream of unsigned 14-bit converter codes from a bank of channels and turns every sample into an in-phase and a quadrature product. The 96 channels arrive one after another inside each sample period, and these back-to-back groups are called frames. Each code is made signed by removing the mid-scale offset of 8192. The result is then mixed with a carrier at exactly one quarter of the per-channel sample rate.

At that rate the cosine and sine samples take only the values +1, 0 and -1. Mixing therefore needs only pass, zero and negate, with no multiplier. One carrier phase applies to all channels of a frame, and the phase steps forward once per frame rather than once per clock. Each output beat carries the channel index it belongs to, so a downstream bank of low-pass filters can sort the products per channel.

Top module: `qdc_downconv`

## Requirements
- R1: The signed sample value is the input code minus 8192, so code 0 maps to -8192, code 8192 maps to 0 and code 16383 maps to +8191.
- R2: The in-phase output is the signed sample times a cosine weight chosen by the frame phase index 0, 1, 2, 3: +1, 0, -1, 0.
- R3: The quadrature output is the signed sample times a sine weight chosen by the frame phase index 0, 1, 2, 3: 0, +1, 0, -1.
- R4: The channel index on the output is 0 for the first valid beat after reset. It rises by one on each valid beat and returns to 0 after 95.
- R5: The phase index is the same for every beat of a frame. It steps by one (3 wraps to 0) only after the valid beat tagged with channel 95.
- R6: Outputs appear one clock after the input beat, and the output valid equals the input valid of the previous cycle.
- R7: A cycle with input valid low advances neither the channel index nor the phase. The output I, Q and channel values keep their previous contents.
- R8: The outputs are 16-bit two's complement. Negating -8192 gives +8192 with no wrap.
- R9: Reset clears the output valid, I, Q and channel index to 0 and returns the channel index to 0 and the phase to index 0. Reset takes effect at once and is released on a clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input beat present |
| in_code | input | 14 | Unsigned converter code |
| out_valid | output | 1 | Output beat present |
| out_i | output | 16 | Signed in-phase product |
| out_q | output | 16 | Signed quadrature product |
| out_ch | output | 7 | Channel index of the output beat |

## Verification
Several whole frames run back to back, so the phase goes through all four weights and wraps back to index 0. A design that advanced the phase on every beat, or that put cosine and sine in the wrong order, would show wrong I/Q values partway into the first frame.

Idle cycles are placed inside frames and across a frame boundary. A design that counted idle cycles would then report shifted channel indices and the phase would move early.

The full-scale codes 0 and 16383 are driven in both negating phases. A design with too narrow an intermediate would produce -8192 in place of +8192.

A reset in the middle of a frame must bring the next beat back to channel 0 with the +1 cosine weight.

// File: rtl/qdc_pkg.sv
package qdc_pkg;

  typedef enum logic [1:0] {
    WT_ZERO = 2'd0,
    WT_POS  = 2'd1,
    WT_NEG  = 2'd2
  } weight_e;

  localparam int PHASE_W = 2;

endpackage

// File: rtl/qdc_rst_sync.sv
module qdc_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_o
);

  logic stage_q;
  logic out_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      stage_q <= 1'b0;
      out_q   <= 1'b0;
    end else begin
      stage_q <= 1'b1;
      out_q   <= stage_q;
    end
  end

  assign rst_n_o = out_q;

endmodule

// File: rtl/qdc_frame_seq.sv
module qdc_frame_seq #(
  parameter int N_CH = 96,
  localparam int CH_W = (N_CH > 1) ? $clog2(N_CH) : 1
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          adv,
  output logic [CH_W-1:0]               ch_idx,
  output logic [qdc_pkg::PHASE_W-1:0]   phase
);

  localparam logic [CH_W-1:0] LAST_CH = CH_W'(N_CH - 1);

  logic [CH_W-1:0]             ch_q, ch_nxt;
  logic [qdc_pkg::PHASE_W-1:0] ph_q, ph_nxt;
  logic                        frame_end;

  assign frame_end = (ch_q == LAST_CH);

  always_comb begin
    ch_nxt = ch_q;
    ph_nxt = ph_q;
    if (frame_end) begin
      ch_nxt = '0;
      ph_nxt = ph_q + 1'b1;
    end else begin
      ch_nxt = ch_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ch_q <= '0;
      ph_q <= '0;
    end else if (adv) begin
      ch_q <= ch_nxt;
      ph_q <= ph_nxt;
    end
  end

  assign ch_idx = ch_q;
  assign phase  = ph_q;

  // R4: wrap back to channel 0 after the last channel
  a_r4_ch_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && ch_q == LAST_CH) |=> (ch_q == '0));

  // R5: phase steps by one at a frame end
  a_r5_phase_step: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && ch_q == LAST_CH) |=> (ph_q == $past(ph_q) + 1'b1));

  // R5: phase is held inside a frame
  a_r5_phase_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !(adv && ch_q == LAST_CH) |=> $stable(ph_q));

  // R7: idle cycles do not move the channel index
  a_r7_ch_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !adv |=> $stable(ch_q));

endmodule

// File: rtl/qdc_carrier.sv
module qdc_carrier (
  input  logic [qdc_pkg::PHASE_W-1:0] phase,
  output qdc_pkg::weight_e            cos_w,
  output qdc_pkg::weight_e            sin_w
);
  import qdc_pkg::*;

  always_comb begin
    unique case (phase)
      2'd0: begin cos_w = WT_POS;  sin_w = WT_ZERO; end
      2'd1: begin cos_w = WT_ZERO; sin_w = WT_POS;  end
      2'd2: begin cos_w = WT_NEG;  sin_w = WT_ZERO; end
      default: begin cos_w = WT_ZERO; sin_w = WT_NEG; end
    endcase
  end

  // R2 R3: cosine and sine are never both non-zero
  always_comb begin
    a_r2_r3_quadrature: assert ((cos_w == WT_ZERO) != (sin_w == WT_ZERO));
  end

endmodule

// File: rtl/qdc_mix_lane.sv
module qdc_mix_lane #(
  parameter int IN_W  = 14,
  parameter int OUT_W = 16
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    en,
  input  logic signed [IN_W-1:0]  smp,
  input  qdc_pkg::weight_e        wt,
  output logic signed [OUT_W-1:0] y
);
  import qdc_pkg::*;

  localparam int EXT_W = OUT_W - IN_W;
  localparam logic signed [OUT_W-1:0] POS_LIM = OUT_W'(2 ** (IN_W - 1));
  localparam logic signed [OUT_W-1:0] NEG_LIM = -POS_LIM;

  logic signed [OUT_W-1:0] smp_ext;
  logic signed [OUT_W-1:0] prod;
  logic signed [OUT_W-1:0] y_q;

  assign smp_ext = {{EXT_W{smp[IN_W-1]}}, smp};

  always_comb begin
    unique case (wt)
      WT_POS:  prod = smp_ext;
      WT_NEG:  prod = -smp_ext;
      default: prod = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      y_q <= '0;
    end else if (en) begin
      y_q <= prod;
    end
  end

  assign y = y_q;

  // R2 R3: a zero weight yields a zero product
  a_r2_zero_weight: assert property (@(posedge clk) disable iff (!rst_n)
    (en && wt == WT_ZERO) |=> (y_q == '0));

  // R8: output stays within the negated input range
  a_r8_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    (y_q <= POS_LIM) && (y_q >= NEG_LIM));

endmodule

// File: rtl/qdc_downconv.sv
module qdc_downconv #(
  parameter int N_CH  = 96,
  parameter int IN_W  = 14,
  parameter int OUT_W = 16,
  localparam int CH_W = (N_CH > 1) ? $clog2(N_CH) : 1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    in_valid,
  input  logic [IN_W-1:0]         in_code,
  output logic                    out_valid,
  output logic signed [OUT_W-1:0] out_i,
  output logic signed [OUT_W-1:0] out_q,
  output logic [CH_W-1:0]         out_ch
);
  import qdc_pkg::*;

  localparam int N_LANE = 2;

  logic                    srst_n;
  logic [CH_W-1:0]         ch_idx;
  logic [PHASE_W-1:0]      phase;
  weight_e                 cos_w, sin_w;
  logic signed [IN_W-1:0]  smp;
  logic signed [OUT_W-1:0] lane_y [N_LANE];
  logic                    vld_q;
  logic [CH_W-1:0]         ch_q;

  qdc_rst_sync u_rst (
    .clk     (clk),
    .arst_n  (rst_n),
    .rst_n_o (srst_n)
  );

  qdc_frame_seq #(.N_CH(N_CH)) u_seq (
    .clk    (clk),
    .rst_n  (srst_n),
    .adv    (in_valid),
    .ch_idx (ch_idx),
    .phase  (phase)
  );

  qdc_carrier u_car (
    .phase (phase),
    .cos_w (cos_w),
    .sin_w (sin_w)
  );

  // Offset-binary to two's complement: invert the top bit
  assign smp = {~in_code[IN_W-1], in_code[IN_W-2:0]};

  for (genvar L = 0; L < N_LANE; L++) begin : g_lane
    weight_e lane_w;
    assign lane_w = (L == 0) ? cos_w : sin_w;
    qdc_mix_lane #(.IN_W(IN_W), .OUT_W(OUT_W)) u_mix (
      .clk   (clk),
      .rst_n (srst_n),
      .en    (in_valid),
      .smp   (smp),
      .wt    (lane_w),
      .y     (lane_y[L])
    );
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      vld_q <= 1'b0;
    end else begin
      vld_q <= in_valid;
    end
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      ch_q <= '0;
    end else if (in_valid) begin
      ch_q <= ch_idx;
    end
  end

  assign out_valid = vld_q;
  assign out_i     = lane_y[0];
  assign out_q     = lane_y[1];
  assign out_ch    = ch_q;

  // R6: output valid follows input valid by one cycle
  a_r6_valid_follow: assert property (@(posedge clk) disable iff (!srst_n)
    in_valid |=> out_valid);
  a_r6_valid_drop: assert property (@(posedge clk) disable iff (!srst_n)
    !in_valid |=> !out_valid);

  // R7: outputs hold across idle cycles
  a_r7_out_hold: assert property (@(posedge clk) disable iff (!srst_n)
    !in_valid |=> ($stable(out_i) && $stable(out_q) && $stable(out_ch)));

endmodule

// File: tb/tb_qdc_downconv.sv
module tb_qdc_downconv;

  localparam int N_CH = 96;
  localparam int NV   = 8;
  localparam int WDOG = 200000;

  localparam logic [13:0] VEC_CODE [NV] = '{14'd0, 14'd16383, 14'd8192, 14'd8191,
                                            14'd1, 14'd12345, 14'd4000, 14'd9000};
  localparam int VEC_VAL [NV] = '{-8192, 8191, 0, -1, -8191, 4153, -4192, 808};

  logic              clk = 1'b0;
  logic              rst_n;
  logic              in_valid;
  logic [13:0]       in_code;
  logic              out_valid;
  logic signed [15:0] out_i, out_q;
  logic [6:0]        out_ch;

  always #10 clk = ~clk;

  qdc_downconv dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_code(in_code),
    .out_valid(out_valid), .out_i(out_i), .out_q(out_q), .out_ch(out_ch)
  );

  int n_chk = 0;
  int n_bad = 0;
  int m_ch = 0, m_ph = 0;
  int exp_i = 0, exp_q = 0, exp_ch = 0, exp_v = 0;
  bit pend = 0;
  string tag_iq = "R2 R3";
  int cyc = 0;

  function automatic int cw(int p);
    case (p) 0: return 1; 2: return -1; default: return 0; endcase
  endfunction
  function automatic int sw(int p);
    case (p) 1: return 1; 3: return -1; default: return 0; endcase
  endfunction

  task automatic check(string req, int act, int expv);
    n_chk++;
    if (act != expv) begin
      n_bad++;
      $display("FAIL %s actual %0d expected %0d", req, act, expv);
    end
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  // One cycle: check previous beat's result, then drive a new beat
  task automatic beat(bit v, logic [13:0] code, int sval, string tag);
    @(negedge clk);
    if (pend) begin
      check("R6 valid", int'(out_valid), exp_v);
      check({tag, " I"}, int'(out_i), exp_i);
      check({tag, " Q"}, int'(out_q), exp_q);
      check("R4 R5 channel", int'(out_ch), exp_ch);
    end
    in_valid = v;
    in_code  = code;
    pend = 1;
    exp_v = v;
    if (v) begin
      exp_i  = sval * cw(m_ph);
      exp_q  = sval * sw(m_ph);
      exp_ch = m_ch;
      if (m_ch == N_CH - 1) begin m_ch = 0; m_ph = (m_ph + 1) % 4; end
      else m_ch++;
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    in_valid = 1'b0;
    #1;
    // R9: asynchronous clear
    check("R9 valid", int'(out_valid), 0);
    check("R9 I", int'(out_i), 0);
    check("R9 Q", int'(out_q), 0);
    check("R9 channel", int'(out_ch), 0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    m_ch = 0; m_ph = 0;
    exp_i = 0; exp_q = 0; exp_ch = 0; exp_v = 0;
    pend = 1;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > WDOG) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual %0d expected below %0d", cyc, WDOG);
      finish_run();
    end
  end

  initial begin
    rst_n = 1'b0;
    in_valid = 1'b0;
    in_code = '0;
    repeat (3) @(negedge clk);
    // R9: reset state
    check("R9 valid", int'(out_valid), 0);
    check("R9 I", int'(out_i), 0);
    check("R9 Q", int'(out_q), 0);
    check("R9 channel", int'(out_ch), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    pend = 1;

    // R1 R2 R3 R4 R5 R6: vector table over five contiguous frames
    for (int k = 0; k < 5 * N_CH; k++)
      beat(1'b1, VEC_CODE[k % NV], VEC_VAL[k % NV], "R1 R2 R3 R5");

    // R7: idle gaps every fifth cycle, across a frame boundary
    for (int k = 0; k < 2 * N_CH + 40; k++) begin
      if (k % 5 == 4) beat(1'b0, 14'h2aaa, 0, "R7 hold");
      else beat(1'b1, VEC_CODE[(k * 3) % NV], VEC_VAL[(k * 3) % NV], "R7 R2 R3");
    end
    beat(1'b0, 14'h1555, 0, "R7 hold");
    beat(1'b0, 14'h0, 0, "R7 hold");

    // R8: full scale in every phase, covering both negating phases
    for (int k = 0; k < 4 * N_CH; k++) begin
      if (k % 2 == 0) beat(1'b1, 14'd0, -8192, "R8 R1");
      else beat(1'b1, 14'd16383, 8191, "R8 R1");
    end

    // R9: reset in mid-frame, then restart at channel 0, phase 0
    for (int k = 0; k < N_CH + 40; k++)
      beat(1'b1, VEC_CODE[k % NV], VEC_VAL[k % NV], "R2 R3");
    beat(1'b0, 14'h0, 0, "R7 hold");
    do_reset();
    for (int k = 0; k < 6; k++)
      beat(1'b1, VEC_CODE[(k + 5) % NV], VEC_VAL[(k + 5) % NV], "R9 R2 R3");
    beat(1'b0, 14'h0, 0, "R7 hold");
    beat(1'b0, 14'h0, 0, "R7 hold");

    finish_run();
  end

endmodule